// File: doc/BRIEF.md
# Serial Flash Deep Power-Down Controller

This block is the slave-side instruction front end of a serial NOR flash that owns the deep power-down state. It watches chip select, serial clock and the IO lines. The opcode byte arrives in one of two ways: one bit per clock on a single line, or one nibble per clock on four lines. Once the byte is complete, the block decides whether the instruction counts. It then either passes it to the rest of the device as a one-cycle strobe, or drops it.

A power-down opcode that is framed correctly starts a programmable entry delay, after which the device reports power-down. While in power-down, only the release opcode is honoured, and it starts a second programmable delay back to standby. Any frame that finishes while either delay is running has no effect.

Chip select, serial clock, the IO lines and the mode select are assumed to be already synchronous to the system clock. The serial clock must be slow enough that every level lasts at least one system clock cycle.

Top module: `sdp_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `pd_active` and `instr_valid` are 0 and `opcode` is 0x00. The device always starts in standby.
- R2: With `quad_sel`=0, one bit is taken from `io[0]` on each sampled rising edge of `sclk` while `csn` is low, most significant bit first. This works whether `sclk` idles low or high when `csn` falls.
- R3: With `quad_sel`=1, one nibble is taken from `io[3:0]` (with `io[3]` as the most significant) on each rising edge of `sclk`, high nibble first. The byte is complete after 2 clocks.
- R4: A frame counts only if `csn` rises when exactly 8 bits have been received. A frame that ends short or runs long gives no strobe and leaves the power state unchanged.
- R5: In standby, a frame that counts raises `instr_valid` for exactly one cycle, in the cycle after the system clock edge that samples the `csn` rise. `opcode` carries the received byte in that cycle.
- R6: In standby, a frame that counts and carries 0xB9 makes `pd_active` rise exactly T_DP cycles after the strobe edge.
- R7: In power-down, every opcode other than 0xAB is ignored: it gives no strobe, and `pd_active` stays 1.
- R8: In power-down, a frame that counts and carries 0xAB gives a strobe, and `pd_active` falls exactly T_RES cycles after the strobe edge.
- R9: A frame that finishes during the entry or release delay gives no strobe and changes neither the delay nor the target state.
- R10: In standby, 0xAB gives a strobe with no change of power state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csn | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, sampled by clk |
| io | input | 4 | Data lines; io[0] only in single-line mode |
| quad_sel | input | 1 | 1 selects nibble-wide instruction transfer |
| pd_active | output | 1 | 1 while the device is powered down (including during the release delay) |
| instr_valid | output | 1 | One-cycle strobe for an accepted instruction |
| opcode | output | 8 | Last accepted opcode |

## Verification
A wrong bit count or shift order shows up as a missing strobe or a wrong `opcode` on the cycle after the `csn` rise, so it is visible within one frame. A wrong state or delay value shows up as `pd_active` moving on the wrong cycle, or as a strobe leaking through while gated. The bench compares every output against a behavioural model on every clock, so any error of this kind is caught on the first cycle where it differs.

// File: rtl/sdp_pkg.sv
// Shared constants and types for the deep power-down controller.
// Assumes nothing beyond IEEE 1800-2017.
package sdp_pkg;
    localparam logic [7:0] OP_POWER_DOWN = 8'hB9;
    localparam logic [7:0] OP_RELEASE    = 8'hAB;
    localparam int         BYTE_BITS     = 8;
    localparam int         QUAD_LANES    = 4;

    typedef enum logic [1:0] {
        PS_STANDBY  = 2'd0,
        PS_ENTERING = 2'd1,
        PS_DOWN     = 2'd2,
        PS_WAKING   = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/sdp_pin_sampler.sv
// Registers chip select and serial clock and detects their rising edges.
// Assumes the pins are already synchronous to clk.
module sdp_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic csn,
    input  logic sclk,
    output logic sclk_rise,
    output logic csn_rise
);
    logic sclk_q;
    logic csn_q;

    // Hold the previous levels of both pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk;
            csn_q  <= csn;
        end
    end

    // A rise is a high level now after a low level on the last cycle.
    always_comb begin
        sclk_rise = sclk & ~sclk_q;
        csn_rise  = csn & ~csn_q;
    end
endmodule

// File: rtl/sdp_opcode_shifter.sv
// Assembles the opcode byte in single-line or nibble mode and reports a
// correctly framed byte at the chip-select rise. Assumes quad_sel is held
// steady for the duration of a frame.
module sdp_opcode_shifter #(
    parameter int BITS  = sdp_pkg::BYTE_BITS,
    parameter int LANES = sdp_pkg::QUAD_LANES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csn,
    input  logic            sclk_rise,
    input  logic            csn_rise,
    input  logic            quad_sel,
    input  logic [LANES-1:0] io,
    output logic            frame_done,
    output logic [BITS-1:0] frame_byte
);
    localparam int CNT_W = $clog2(BITS + LANES + 1);

    logic [BITS-1:0]  shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic             overrun;
    logic [CNT_W-1:0] step;
    logic [CNT_W:0]   next_cnt;
    logic [BITS-1:0]  shifted;

    // Pick the shift width and the new register contents for the active mode.
    always_comb begin
        if (quad_sel) begin
            step    = CNT_W'(LANES);
            shifted = {shreg[BITS-LANES-1:0], io};
        end else begin
            step    = CNT_W'(1);
            shifted = {shreg[BITS-2:0], io[0]};
        end
        next_cnt = {1'b0, bit_cnt} + {1'b0, step};
    end

    // Shift on sclk rises while selected; clear all framing state when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            overrun <= 1'b0;
        end else if (csn) begin
            bit_cnt <= '0;
            overrun <= 1'b0;
        end else if (sclk_rise) begin
            shreg <= shifted;
            if (overrun || next_cnt > (CNT_W+1)'(BITS)) begin
                overrun <= 1'b1;
            end else begin
                bit_cnt <= next_cnt[CNT_W-1:0];
            end
        end
    end

    // A frame counts only if exactly one byte was clocked when csn rises.
    always_comb begin
        frame_done = csn_rise && !overrun && (bit_cnt == CNT_W'(BITS));
        frame_byte = shreg;
    end

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(BITS));
    p_clear_on_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        csn |=> (bit_cnt == '0) && !overrun);
endmodule

// File: rtl/sdp_power_fsm.sv
// Power state machine with entry and release delay counters.
// Assumes T_DP and T_RES are at least 1.
module sdp_power_fsm
    import sdp_pkg::*;
#(
    parameter int T_DP  = 64,
    parameter int T_RES = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_done,
    input  logic [7:0] frame_byte,
    output logic       cmd_accept,
    output logic       pd_active
);
    localparam int MAXD  = (T_DP > T_RES) ? T_DP : T_RES;
    localparam int CNT_W = $clog2(MAXD + 1);

    pwr_state_t       state;
    logic [CNT_W-1:0] remain;

    // Decide whether a finished frame is allowed through in the current state.
    always_comb begin
        unique case (state)
            PS_STANDBY: cmd_accept = frame_done;
            PS_DOWN:    cmd_accept = frame_done && (frame_byte == OP_RELEASE);
            default:    cmd_accept = 1'b0;
        endcase
        pd_active = (state == PS_DOWN) || (state == PS_WAKING);
    end

    // Move between power states, running the delay counters on transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PS_STANDBY;
            remain <= '0;
        end else begin
            unique case (state)
                PS_STANDBY: if (cmd_accept && frame_byte == OP_POWER_DOWN) begin
                    state  <= PS_ENTERING;
                    remain <= CNT_W'(T_DP - 1);
                end
                PS_ENTERING: if (remain == '0) state <= PS_DOWN;
                             else remain <= remain - 1'b1;
                PS_DOWN: if (cmd_accept) begin
                    state  <= PS_WAKING;
                    remain <= CNT_W'(T_RES - 1);
                end
                PS_WAKING: if (remain == '0) state <= PS_STANDBY;
                           else remain <= remain - 1'b1;
                default: state <= PS_STANDBY;
            endcase
        end
    end

    p_pd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_DOWN) && !cmd_accept |=> pd_active);
    p_enter_only_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ENTERING) |=> (state == PS_ENTERING) || (state == PS_DOWN));
    p_window_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ENTERING || state == PS_WAKING) |-> !cmd_accept);
endmodule

// File: rtl/sdp_ctrl.sv
// Top of the deep power-down controller: pin sampling, opcode assembly,
// power state control and the registered instruction strobe.
// Assumes all pins are synchronous to clk and sclk levels last >= 1 clk cycle.
module sdp_ctrl #(
    parameter int T_DP  = 64,
    parameter int T_RES = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csn,
    input  logic       sclk,
    input  logic [3:0] io,
    input  logic       quad_sel,
    output logic       pd_active,
    output logic       instr_valid,
    output logic [7:0] opcode
);
    logic       sclk_rise;
    logic       csn_rise;
    logic       frame_done;
    logic [7:0] frame_byte;
    logic       cmd_accept;

    sdp_pin_sampler u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn       (csn),
        .sclk      (sclk),
        .sclk_rise (sclk_rise),
        .csn_rise  (csn_rise)
    );

    sdp_opcode_shifter #(.BITS(8), .LANES(4)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .csn        (csn),
        .sclk_rise  (sclk_rise),
        .csn_rise   (csn_rise),
        .quad_sel   (quad_sel),
        .io         (io),
        .frame_done (frame_done),
        .frame_byte (frame_byte)
    );

    sdp_power_fsm #(.T_DP(T_DP), .T_RES(T_RES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_byte (frame_byte),
        .cmd_accept (cmd_accept),
        .pd_active  (pd_active)
    );

    // Register the strobe and the accepted opcode for the rest of the device.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_valid <= 1'b0;
            opcode      <= 8'h00;
        end else begin
            instr_valid <= cmd_accept;
            if (cmd_accept) opcode <= frame_byte;
        end
    end

    p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> !instr_valid);
    p_gate_in_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && $past(pd_active) |-> opcode == sdp_pkg::OP_RELEASE);
endmodule

// File: tb/sdp_ctrl_tb.sv
// Bench: drives frames on the falling clock edge, runs a behavioural model on
// the rising edge and compares all outputs on every falling edge.
module sdp_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TDP  = 60;
    localparam int TRES = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csn = 1'b1;
    logic       sclk = 1'b0;
    logic [3:0] io = 4'h0;
    logic       quad_sel = 1'b0;
    logic       pd_active;
    logic       instr_valid;
    logic [7:0] opcode;

    int n_cmp = 0;
    int n_bad = 0;
    int strobes = 0;
    int cycles = 0;
    bit running = 1'b0;

    // model state
    bit   q_bits[$];
    bit   m_sclk_prev = 1'b0;
    bit   m_csn_prev = 1'b1;
    int   m_phase = 0;   // 0 standby, 1 entering, 2 down, 3 waking
    int   m_timer = 0;
    bit   m_iv = 1'b0;
    bit [7:0] m_op = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdp_ctrl #(.T_DP(TDP), .T_RES(TRES)) dut_i (
        .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .io(io),
        .quad_sel(quad_sel), .pd_active(pd_active),
        .instr_valid(instr_valid), .opcode(opcode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced on every rising clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q_bits.delete();
            m_sclk_prev = 1'b0; m_csn_prev = 1'b1;
            m_phase = 0; m_timer = 0; m_iv = 1'b0; m_op = 8'h00;
        end else begin
            bit good;
            bit [7:0] byte_v;
            good = csn && !m_csn_prev && (q_bits.size() == 8);
            byte_v = 8'h00;
            if (good) for (int k = 0; k < 8; k++) byte_v[7-k] = q_bits[k];
            m_iv = 1'b0;
            if (m_phase == 1 || m_phase == 3) begin
                m_timer--;
                if (m_timer == 0) m_phase = (m_phase == 1) ? 2 : 0;
            end else if (good) begin
                if (m_phase == 0) begin
                    m_iv = 1'b1; m_op = byte_v;
                    if (byte_v == 8'hB9) begin m_phase = 1; m_timer = TDP; end
                end else if (byte_v == 8'hAB) begin
                    m_iv = 1'b1; m_op = byte_v;
                    m_phase = 3; m_timer = TRES;
                end
            end
            if (csn) q_bits.delete();
            else if (sclk && !m_sclk_prev) begin
                if (quad_sel) for (int k = 3; k >= 0; k--) q_bits.push_back(io[k]);
                else q_bits.push_back(io[0]);
            end
            m_sclk_prev = sclk; m_csn_prev = csn;
        end
    end

    // Compare outputs on every falling edge.
    always @(negedge clk) begin
        if (running) begin
            check(pd_active == (m_phase >= 2), "R6/R8 pd_active", pd_active, m_phase >= 2);
            check(instr_valid == m_iv, "R5 instr_valid", instr_valid, m_iv);
            if (m_iv) check(opcode == m_op, "R2 opcode", opcode, m_op);
            if (instr_valid) strobes++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // units = bits (single line) or nibbles (quad); extra units carry zero.
    task automatic send(input logic [7:0] b, input int units, input bit quad, input bit idle_hi);
        quad_sel = quad; sclk = idle_hi; tick(1);
        csn = 1'b0; tick(1);
        for (int u = 0; u < units; u++) begin
            sclk = 1'b0;
            if (quad) io = (u < 2) ? ((u == 0) ? b[7:4] : b[3:0]) : 4'h0;
            else      io = {3'b000, (u < 8) ? b[7-u] : 1'b0};
            tick(2);
            sclk = 1'b1; tick(2);
        end
        if (!idle_hi) begin sclk = 1'b0; tick(1); end
        csn = 1'b1; tick(3);
    endtask

    initial begin
        int s0;
        tick(3);
        check(pd_active == 1'b0 && instr_valid == 1'b0 && opcode == 8'h00, "R1 reset", opcode, 0);
        rst_n = 1'b1; running = 1'b1;
        tick(1);
        check(pd_active == 1'b0 && opcode == 8'h00, "R1 after release", pd_active, 0);

        s0 = strobes; send(8'h9F, 8, 0, 0);
        check(strobes - s0 == 1 && opcode == 8'h9F, "R2 mode0 byte", opcode, 8'h9F);
        s0 = strobes; send(8'h05, 8, 0, 1);
        check(strobes - s0 == 1 && opcode == 8'h05, "R2 mode3 byte", opcode, 8'h05);
        s0 = strobes; send(8'h38, 2, 1, 0);
        check(strobes - s0 == 1 && opcode == 8'h38, "R3 quad byte", opcode, 8'h38);

        s0 = strobes; send(8'hB9, 7, 0, 0); send(8'hB9, 9, 0, 0); send(8'hB9, 3, 1, 0);
        tick(TDP + 5);
        check(strobes == s0 && pd_active == 1'b0, "R4 misframed", strobes - s0, 0);

        s0 = strobes; send(8'hAB, 8, 0, 0); tick(TDP);
        check(strobes - s0 == 1 && pd_active == 1'b0, "R10 release in standby", pd_active, 0);

        s0 = strobes; send(8'hB9, 2, 1, 0);
        send(8'hAB, 2, 1, 0); send(8'h05, 2, 1, 0);
        check(strobes - s0 == 1 && pd_active == 1'b0, "R9 entry window", strobes - s0, 1);
        tick(TDP);
        check(pd_active == 1'b1, "R6 powered down", pd_active, 1);

        s0 = strobes; send(8'h05, 8, 0, 0); send(8'h9F, 2, 1, 0); send(8'hB9, 8, 0, 1);
        check(strobes == s0 && pd_active == 1'b1, "R7 gated in down", strobes - s0, 0);

        s0 = strobes; send(8'hAB, 2, 1, 0); send(8'hB9, 2, 1, 0);
        check(strobes - s0 == 1 && pd_active == 1'b1, "R9 release window", strobes - s0, 1);
        tick(TRES);
        check(pd_active == 1'b0, "R8 back to standby", pd_active, 0);

        s0 = strobes; send(8'hB9, 8, 0, 1); tick(TDP + 2);
        check(pd_active == 1'b1, "R6 spi entry", pd_active, 1);
        send(8'hAB, 8, 0, 0); tick(TRES + 2);
        check(strobes - s0 == 2 && pd_active == 1'b0, "R8 spi release", strobes - s0, 2);

        running = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule